// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits at the address phase of a two-sided bus bridge and decides whether a transaction crosses the bridge and in which direction. Each address is compared against three programmable windows: an I/O range, a non-prefetchable memory range and a prefetchable memory range. The window result is then modified by two legacy rules. The first drops the upper three quarters of every 1 KB I/O block, for 16-bit addresses only. The second forces the display-adapter legacy ranges downstream.

A transaction that arrives on the primary side and is claimed by the windows or the legacy ranges is forwarded downstream. A transaction on the primary side that is not claimed is ignored. A transaction on the secondary side is forwarded upstream exactly when the same address would not be claimed downstream. The result of each request is registered and presented one clock after the request strobe. The register file that holds the window fields, the bus protocol and the data buffering are outside this block.

Top module: `wdec_top`

## Requirements
- R1: Reset clears `decVld`, `fwdDown`, `fwdUp` and `pfHit`. A request presented with `addrValid`=1 at a rising edge produces `decVld`=1 and its decision outputs right after that edge. On any cycle without such a request, all four outputs are 0.
- R2: The I/O window runs from {U, `ioBase`[7:4], 000h} through {V, `ioLimit`[7:4], FFFh}, both ends included. When `ioBase`[3:0]=1h, U=`ioBaseUpper` and V=`ioLimitUpper`; otherwise U=V=0, which makes it a 16-bit window.
- R3: The memory window runs from {`memBase`[15:4], 00000h} through {`memLimit`[15:4], FFFFFh}, both ends included. Bits [3:0] of both fields are ignored.
- R4: The prefetchable window is compared on 64 bits, with the 32-bit address zero-extended. It runs from {P, `pfBase`[15:4], 00000h} through {Q, `pfLimit`[15:4], FFFFFh}. When `pfBase`[3:0]=1h, P=`pfBaseUpper` and Q=`pfLimitUpper`; otherwise P=Q=0. `pfHit`=1 only for a memory transaction that is forwarded downstream and lies inside this window.
- R5: Any window whose lower bound exceeds its upper bound matches no address.
- R6: With `isaEn`=1, an I/O address whose bits [31:16] are zero and whose bits [9:8] are not 00 is not claimed by the I/O window. I/O addresses with nonzero bits [31:16] are unaffected by this rule.
- R7: With `vgaEn`=1, the following are claimed whatever the windows hold and whether or not the ISA rule applies: memory addresses A0000h to BFFFFh, and I/O addresses with bits [31:16] zero whose bits [9:0] fall in 3B0h to 3BBh or 3C0h to 3DFh. Bits [15:10] are ignored, so aliases are included.
- R8: A primary-side request (`fromSecondary`=0) raises `fwdDown` when claimed and never raises `fwdUp`. A secondary-side request raises `fwdUp` when not claimed and never raises `fwdDown`.
- R9: An I/O request forwards in neither direction unless `ioSpaceEn`=1. A memory request forwards in neither direction unless `memSpaceEn`=1.
- R10: `fwdDown` and `fwdUp` are never 1 together, and `pfHit` is never 1 without `fwdDown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Address phase request strobe |
| addr | input | 32 | Transaction address |
| isIo | input | 1 | 1 = I/O space, 0 = memory space |
| fromSecondary | input | 1 | 1 = arrived on secondary side |
| ioSpaceEn | input | 1 | I/O space enable |
| memSpaceEn | input | 1 | Memory space enable |
| isaEn | input | 1 | ISA alias filter enable |
| vgaEn | input | 1 | Legacy display range enable |
| ioBase | input | 8 | I/O base field |
| ioLimit | input | 8 | I/O limit field |
| ioBaseUpper | input | 16 | I/O base address bits [31:16] |
| ioLimitUpper | input | 16 | I/O limit address bits [31:16] |
| memBase | input | 16 | Memory base field |
| memLimit | input | 16 | Memory limit field |
| pfBase | input | 16 | Prefetchable base field |
| pfLimit | input | 16 | Prefetchable limit field |
| pfBaseUpper | input | 32 | Prefetchable base bits [63:32] |
| pfLimitUpper | input | 32 | Prefetchable limit bits [63:32] |
| decVld | output | 1 | Decision valid |
| fwdDown | output | 1 | Forward downstream |
| fwdUp | output | 1 | Forward upstream |
| pfHit | output | 1 | Downstream hit in prefetchable window |

## Verification
The assertions check on every cycle that the two directions are exclusive, that `pfHit` implies `fwdDown`, that outputs are quiet without a decision, and that each request yields a decision. They also check that secondary requests never go downstream, that disabled spaces never forward, and that enabled legacy ranges from the primary side always go downstream. The window bounds cannot be shown by these properties. Only the bench scenarios show them: the exact inclusive edges, the granule ends, the base-above-limit disable, the 32-bit and 64-bit upper fields, and the interaction of the ISA filter with 32-bit I/O addresses and with the legacy ranges.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  localparam int ADDR_W   = 32;
  localparam int WIDE_W   = 64;
  localparam int IO_GRAN  = 12;
  localparam int MEM_GRAN = 20;
  localparam int NUM_WIN  = 3;
  localparam int WIN_IO   = 0;
  localparam int WIN_MEM  = 1;
  localparam int WIN_PF   = 2;
  localparam logic [3:0] UPPER_ON = 4'h1;

  typedef struct packed {
    logic ioWin;
    logic memWin;
    logic pfWin;
    logic isaAlias;
    logic vgaIo;
    logic vgaMem;
  } winFlags_t;
endpackage

// File: rtl/wdec_range.sv
module wdec_range #(
  parameter int W = 64
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] val,
  output logic         hit
);
  always_comb hit = (lo <= hi) && (val >= lo) && (val <= hi);
endmodule

// File: rtl/wdec_datapath.sv
module wdec_datapath
  import wdec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ioBase,
  input  logic [7:0]        ioLimit,
  input  logic [15:0]       ioBaseUpper,
  input  logic [15:0]       ioLimitUpper,
  input  logic [15:0]       memBase,
  input  logic [15:0]       memLimit,
  input  logic [15:0]       pfBase,
  input  logic [15:0]       pfLimit,
  input  logic [31:0]       pfBaseUpper,
  input  logic [31:0]       pfLimitUpper,
  output winFlags_t         flags
);
  logic [NUM_WIN-1:0][WIDE_W-1:0] loB, hiB;
  logic [NUM_WIN-1:0]             hitV;
  logic [WIDE_W-1:0]              val64;
  logic                           ioUpperOn, pfUpperOn, low64k;

  always_comb begin
    ioUpperOn = (ioBase[3:0] == UPPER_ON);
    pfUpperOn = (pfBase[3:0] == UPPER_ON);
    val64 = {{(WIDE_W-ADDR_W){1'b0}}, addr};
    loB[WIN_IO]  = {32'h0, (ioUpperOn ? ioBaseUpper : 16'h0), ioBase[7:4], {IO_GRAN{1'b0}}};
    hiB[WIN_IO]  = {32'h0, (ioUpperOn ? ioLimitUpper : 16'h0), ioLimit[7:4], {IO_GRAN{1'b1}}};
    loB[WIN_MEM] = {32'h0, memBase[15:4], {MEM_GRAN{1'b0}}};
    hiB[WIN_MEM] = {32'h0, memLimit[15:4], {MEM_GRAN{1'b1}}};
    loB[WIN_PF]  = {(pfUpperOn ? pfBaseUpper : 32'h0), pfBase[15:4], {MEM_GRAN{1'b0}}};
    hiB[WIN_PF]  = {(pfUpperOn ? pfLimitUpper : 32'h0), pfLimit[15:4], {MEM_GRAN{1'b1}}};
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    wdec_range #(.W(WIDE_W)) range_i (
      .lo(loB[g]), .hi(hiB[g]), .val(val64), .hit(hitV[g])
    );
  end

  always_comb begin
    low64k         = (addr[31:16] == 16'h0);
    flags.ioWin    = hitV[WIN_IO];
    flags.memWin   = hitV[WIN_MEM];
    flags.pfWin    = hitV[WIN_PF];
    flags.isaAlias = low64k && (addr[9:8] != 2'b00);
    flags.vgaMem   = (addr[31:17] == 15'd5);
    flags.vgaIo    = low64k && (((addr[9:4] == 6'h3B) && (addr[3:2] != 2'b11)) ||
                                (addr[9:5] == 5'h1E));
  end
endmodule

// File: rtl/wdec_ctrl.sv
module wdec_ctrl
  import wdec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrValid,
  input  logic      isIo,
  input  logic      fromSecondary,
  input  logic      ioSpaceEn,
  input  logic      memSpaceEn,
  input  logic      isaEn,
  input  logic      vgaEn,
  input  winFlags_t flags,
  output logic      decVld,
  output logic      fwdDown,
  output logic      fwdUp,
  output logic      pfHit
);
  logic spaceOk, winHit, legacyHit, claim, nextDown, nextUp, nextPf;

  always_comb begin
    spaceOk   = isIo ? ioSpaceEn : memSpaceEn;
    winHit    = isIo ? (flags.ioWin && !(isaEn && flags.isaAlias))
                     : (flags.memWin || flags.pfWin);
    legacyHit = vgaEn && (isIo ? flags.vgaIo : flags.vgaMem);
    claim     = legacyHit || winHit;
    nextDown  = addrValid && spaceOk && !fromSecondary && claim;
    nextUp    = addrValid && spaceOk && fromSecondary && !claim;
    nextPf    = nextDown && !isIo && flags.pfWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decVld  <= 1'b0;
      fwdDown <= 1'b0;
      fwdUp   <= 1'b0;
      pfHit   <= 1'b0;
    end else begin
      decVld  <= addrValid;
      fwdDown <= nextDown;
      fwdUp   <= nextUp;
      pfHit   <= nextPf;
    end
  end

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdDown && fwdUp)); // R10
  AST_PF_NEEDS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    pfHit |-> fwdDown); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !decVld |-> !(fwdDown || fwdUp || pfHit)); // R1
  AST_REQ_DECIDED: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> decVld); // R1
  AST_SEC_NOT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && fromSecondary) |=> !fwdDown); // R8
  AST_SPACE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !spaceOk) |=> !(fwdDown || fwdUp)); // R9
  AST_LEGACY_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && spaceOk && !fromSecondary && legacyHit) |=> fwdDown); // R7
endmodule

// File: rtl/wdec_top.sv
module wdec_top
  import wdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  input  logic [31:0] addr,
  input  logic        isIo,
  input  logic        fromSecondary,
  input  logic        ioSpaceEn,
  input  logic        memSpaceEn,
  input  logic        isaEn,
  input  logic        vgaEn,
  input  logic [7:0]  ioBase,
  input  logic [7:0]  ioLimit,
  input  logic [15:0] ioBaseUpper,
  input  logic [15:0] ioLimitUpper,
  input  logic [15:0] memBase,
  input  logic [15:0] memLimit,
  input  logic [15:0] pfBase,
  input  logic [15:0] pfLimit,
  input  logic [31:0] pfBaseUpper,
  input  logic [31:0] pfLimitUpper,
  output logic        decVld,
  output logic        fwdDown,
  output logic        fwdUp,
  output logic        pfHit
);
  winFlags_t flags;

  wdec_datapath dp_i (
    .addr(addr), .ioBase(ioBase), .ioLimit(ioLimit),
    .ioBaseUpper(ioBaseUpper), .ioLimitUpper(ioLimitUpper),
    .memBase(memBase), .memLimit(memLimit), .pfBase(pfBase), .pfLimit(pfLimit),
    .pfBaseUpper(pfBaseUpper), .pfLimitUpper(pfLimitUpper), .flags(flags)
  );

  wdec_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .isIo(isIo),
    .fromSecondary(fromSecondary), .ioSpaceEn(ioSpaceEn), .memSpaceEn(memSpaceEn),
    .isaEn(isaEn), .vgaEn(vgaEn), .flags(flags), .decVld(decVld),
    .fwdDown(fwdDown), .fwdUp(fwdUp), .pfHit(pfHit)
  );
endmodule

// File: tb/wdec_tb.sv
module wdec_top_tb_top;
  logic clk = 1'b0, rstN = 1'b0, addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic isIo = 0, fromSecondary = 0, ioSpaceEn = 1, memSpaceEn = 1, isaEn = 0, vgaEn = 0;
  logic [7:0]  ioBase = 8'h10, ioLimit = 8'h10;
  logic [15:0] ioBaseUpper = 0, ioLimitUpper = 0;
  logic [15:0] memBase = 16'h0100, memLimit = 16'h01F0, pfBase = 16'h0200, pfLimit = 16'h02F0;
  logic [31:0] pfBaseUpper = 0, pfLimitUpper = 0;
  logic decVld, fwdDown, fwdUp, pfHit;
  int nVec = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdec_top dut_i (.*);

  function automatic logic [2:0] refDecide(logic [31:0] a, logic io, logic sec);
    logic [31:0] lo32, hi32;
    logic [63:0] lo64, hi64;
    logic ioW, memW, pfW, isaA, vIo, vMem, claim, sp, dn, up;
    lo32 = {(ioBase[3:0] == 4'h1) ? ioBaseUpper : 16'h0, ioBase[7:4], 12'h000};
    hi32 = {(ioBase[3:0] == 4'h1) ? ioLimitUpper : 16'h0, ioLimit[7:4], 12'hFFF};
    ioW = (lo32 <= hi32) && a >= lo32 && a <= hi32;
    lo32 = {memBase[15:4], 20'h0};
    hi32 = {memLimit[15:4], 20'hFFFFF};
    memW = (lo32 <= hi32) && a >= lo32 && a <= hi32;
    lo64 = {(pfBase[3:0] == 4'h1) ? pfBaseUpper : 32'h0, pfBase[15:4], 20'h0};
    hi64 = {(pfBase[3:0] == 4'h1) ? pfLimitUpper : 32'h0, pfLimit[15:4], 20'hFFFFF};
    pfW = (lo64 <= hi64) && {32'h0, a} >= lo64 && {32'h0, a} <= hi64;
    isaA = (a < 32'h10000) && (a[9:0] >= 10'h100);
    vMem = (a >= 32'hA0000) && (a <= 32'hBFFFF);
    vIo  = (a < 32'h10000) && ((a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) ||
                               (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF));
    if (io) claim = (ioW && !(isaEn && isaA)) || (vgaEn && vIo);
    else    claim = memW || pfW || (vgaEn && vMem);
    sp = io ? ioSpaceEn : memSpaceEn;
    dn = sp && !sec && claim;
    up = sp && sec && !claim;
    return {dn, up, dn && !io && pfW};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: {vld,down,up,pf} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic runVec(string tag, logic [31:0] a, logic io, logic sec);
    logic [2:0] e;
    @(negedge clk);
    addr = a; isIo = io; fromSecondary = sec; addrValid = 1'b1;
    e = refDecide(a, io, sec);
    @(posedge clk);
    #2;
    addrValid = 1'b0;
    check(tag, {decVld, fwdDown, fwdUp, pfHit}, {1'b1, e});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", {decVld, fwdDown, fwdUp, pfHit}, 4'b0000);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 idle", {decVld, fwdDown, fwdUp, pfHit}, 4'b0000);

    // R2 I/O window 1000h..1FFFh, 16-bit
    runVec("R2 io base", 32'h0000_1000, 1, 0);
    runVec("R2 io limit end", 32'h0000_1FFF, 1, 0);
    runVec("R2 io past limit", 32'h0000_2000, 1, 0);
    runVec("R2 io below base", 32'h0000_0FFF, 1, 0);
    ioBase = 8'h21; ioLimit = 8'h31; ioBaseUpper = 16'h0003; ioLimitUpper = 16'h0003;
    runVec("R2 io32 hit", 32'h0003_2000, 1, 0);
    runVec("R2 io32 end", 32'h0003_3FFF, 1, 0);
    runVec("R2 io32 other upper", 32'h0004_2000, 1, 0);
    isaEn = 1;
    runVec("R6 isa skipped above 64K", 32'h0003_2100, 1, 0);
    isaEn = 0;
    ioBase = 8'h10; ioLimit = 8'h10; ioBaseUpper = 0; ioLimitUpper = 0;

    // R3 memory window 01000000h..01FFFFFFh
    runVec("R3 mem base", 32'h0100_0000, 0, 0);
    runVec("R3 mem end", 32'h01FF_FFFF, 0, 0);
    runVec("R3 mem past", 32'h0200_0000, 0, 0);
    memBase = 16'h010F; memLimit = 16'h0100;
    runVec("R3 low nibble ignored", 32'h010F_FFFF, 0, 0);

    // R4 prefetchable window 02000000h..02FFFFFFh
    memBase = 16'h0100; memLimit = 16'h01F0;
    runVec("R4 pf hit", 32'h0280_0000, 0, 0);
    runVec("R4 pf end", 32'h02FF_FFFF, 0, 0);
    runVec("R4 pf from secondary", 32'h0280_0000, 0, 1);
    pfBase = 16'h0201; pfLimit = 16'h02F1; pfBaseUpper = 32'h1; pfLimitUpper = 32'h1;
    runVec("R4 pf above 4G misses", 32'h0280_0000, 0, 0);
    pfBaseUpper = 0;
    runVec("R4 pf spans 4G", 32'hFFF0_0000, 0, 0);
    pfBase = 16'h0200; pfLimit = 16'h02F0; pfLimitUpper = 0;

    // R5 disabled window
    memBase = 16'h0300; memLimit = 16'h0100;
    runVec("R5 mem base>limit", 32'h0200_0000, 0, 0);
    runVec("R5 mem base>limit sec", 32'h0200_0000, 0, 1);
    ioBase = 8'h50; ioLimit = 8'h20;
    runVec("R5 io base>limit", 32'h0000_3000, 1, 0);
    ioBase = 8'h10; ioLimit = 8'h10; memBase = 16'h0100; memLimit = 16'h01F0;

    // R6 ISA alias filter
    isaEn = 1;
    runVec("R6 isa low quarter", 32'h0000_10FF, 1, 0);
    runVec("R6 isa upper blocked", 32'h0000_1100, 1, 0);
    runVec("R6 isa top blocked", 32'h0000_17FF, 1, 0);
    runVec("R6 isa goes up", 32'h0000_1100, 1, 1);

    // R7 legacy display ranges (isaEn still set)
    vgaEn = 1;
    runVec("R7 vga io 3C0", 32'h0000_03C0, 1, 0);
    runVec("R7 vga io 3DF", 32'h0000_03DF, 1, 0);
    runVec("R7 vga io 3BB", 32'h0000_03BB, 1, 0);
    runVec("R7 vga io 3BC", 32'h0000_03BC, 1, 0);
    runVec("R7 vga io alias 7B0", 32'h0000_77B0, 1, 0);
    runVec("R7 vga io above 64K", 32'h0001_03C0, 1, 0);
    runVec("R7 vga mem A0000", 32'h000A_0000, 0, 0);
    runVec("R7 vga mem BFFFF", 32'h000B_FFFF, 0, 0);
    runVec("R7 vga mem C0000", 32'h000C_0000, 0, 0);
    runVec("R7 vga mem sec", 32'h000A_0000, 0, 1);
    vgaEn = 0;
    runVec("R7 vga off", 32'h000A_0000, 0, 0);
    isaEn = 0;

    // R8 direction
    runVec("R8 primary outside ignored", 32'h0800_0000, 0, 0);
    runVec("R8 secondary outside up", 32'h0800_0000, 0, 1);
    runVec("R8 secondary inside none", 32'h0180_0000, 0, 1);

    // R9 space enables
    ioSpaceEn = 0;
    runVec("R9 io off down", 32'h0000_1000, 1, 0);
    runVec("R9 io off up", 32'h0000_8000, 1, 1);
    runVec("R9 mem on while io off", 32'h0100_0000, 0, 0);
    ioSpaceEn = 1; memSpaceEn = 0;
    runVec("R9 mem off", 32'h0100_0000, 0, 0);
    memSpaceEn = 1;

    // random mix, R10 covered by the reference in every vector
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a;
      logic io;
      ioBase = {4'($urandom % 8), ($urandom % 2) ? 4'h1 : 4'h0};
      ioLimit = {4'($urandom), 4'h1};
      ioBaseUpper = 16'($urandom % 2); ioLimitUpper = 16'($urandom % 3);
      memBase = {12'($urandom % 256), 4'h0}; memLimit = {12'($urandom % 256), 4'h0};
      pfBase = {12'($urandom % 256), ($urandom % 2) ? 4'h1 : 4'h0};
      pfLimit = {12'($urandom % 256), 4'h1};
      pfBaseUpper = 32'($urandom % 2); pfLimitUpper = 32'($urandom % 2);
      isaEn = 1'($urandom); vgaEn = 1'($urandom);
      ioSpaceEn = ($urandom % 8) != 0; memSpaceEn = ($urandom % 8) != 0;
      io = 1'($urandom);
      if (io) a = {16'($urandom % 3), 16'($urandom)};
      else if ($urandom % 4 == 0) a = {12'h000, 4'($urandom % 16), 16'($urandom)};
      else a = {12'($urandom % 256), 20'($urandom)};
      runVec("R10 random", a, io, 1'($urandom));
    end
    @(posedge clk); #2;
    check("R1 idle after run", {decVld, fwdDown, fwdUp, pfHit}, 4'b0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule